// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one column command into the stream of column addresses that a read or write burst visits. When a start pulse arrives it captures the start column, the transfer direction, the burst length code and the ordering type. From the next cycle on it presents one column address per cycle with a valid strobe. A last-beat flag marks the final beat of a fixed-length burst.

Two orderings are offered. Sequential order counts the low address bits upward and wraps inside the aligned block of the burst length, leaving the upper bits alone. Interleaved order XORs the beat index into the low bits of the start column. A full-page setting walks all 256 columns, wrapping from 255 to 0, and runs until a stop request or a new start. A new start may replace a running burst on any cycle and takes effect at once, so column commands can follow each other every cycle. Interleave combined with full page, and the unused length codes, are refused and raise an error output.

Top module: `burst_col_seq`

## Requirements
- R1: After reset col_valid, col_last and mode_err are low.
- R2: A start with a legal setting makes the next cycle show col_valid high, col_out equal to start_col and col_wr equal to start_wr. A fixed burst then gives exactly BL valid cycles, and col_valid is low in the cycle after them unless a new start came.
- R3: Length code bl_sel 0, 1, 2, 3 selects 1, 2, 4, 8 beats and 7 selects full page. With interleave low (sequential), beat i has its low log2(BL) bits equal to (start low bits + i) mod BL and its upper bits equal to those of start_col.
- R4: With interleave high, beat i of a 1, 2, 4 or 8 beat burst is start_col XOR i.
- R5: A full-page burst outputs start_col + i mod 256 on beat i, wraps from 255 to 0, never raises col_last, and keeps col_valid high until a stop or a new start.
- R6: col_last is high only on the final beat of a fixed burst and never while col_valid is low.
- R7: A stop sampled without a start makes col_valid low from the next cycle. A start sampled together with a stop wins.
- R8: A start during a running burst makes the next cycle show beat 0 of the new burst.
- R9: A start with interleave high and full page, or with bl_sel 4, 5 or 6, produces no valid beat, cancels any running burst, and sets mode_err from the next cycle until a start with a legal setting.
- R10: Length, type and start column are captured at start. Changes to bl_sel, interleave, start_col or start_wr while no start is given do not alter the running burst.
- R11: A start on the cycle of a final beat gives an unbroken run of valid cycles into the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new burst this cycle |
| start_col | input | COL_W | First column of the burst |
| start_wr | input | 1 | Direction of the burst, 1 for write |
| stop | input | 1 | End the running burst |
| bl_sel | input | 3 | Burst length code: 0=1, 1=2, 2=4, 3=8, 7=full page |
| interleave | input | 1 | 1 selects interleaved order |
| col_out | output | COL_W | Current column address |
| col_valid | output | 1 | col_out holds a burst beat |
| col_last | output | 1 | Final beat of a fixed burst |
| col_wr | output | 1 | Direction captured at start |
| mode_err | output | 1 | Last start had an illegal setting |

## Verification
The bench goes after a start column in the middle of an aligned block, where a design that added across the whole address would carry into the upper bits instead of wrapping, and after interleaved starts, where a design that counted would visit the wrong order. It runs a full-page burst over the 255 to 0 boundary, which catches a design that stops, raises the last flag or drops valid there. It sends stops, restarts and a start together with a stop in mid-burst, where a late or ignored interrupt would give extra beats, and it changes the mode inputs mid-burst to catch a design that reads them live. Illegal settings are tried on an idle and on a busy sequencer, which finds a design that runs the burst anyway or leaves the old one running.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             stop,
  input  logic [2:0]       bl_sel,
  input  logic             interleave,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic             col_wr,
  output logic             mode_err
);

  localparam logic [2:0] BL_FULL = 3'd7;

  logic             busy_q, full_q, ilv_q, wr_q, err_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q, mask_in;
  logic             full_in, legal_in, final_beat;

  always_comb begin
    mask_in = '0;
    case (bl_sel)
      3'd1:    mask_in = COL_W'(1);
      3'd2:    mask_in = COL_W'(3);
      3'd3:    mask_in = COL_W'(7);
      BL_FULL: mask_in = '1;
      default: mask_in = '0;
    endcase
  end

  assign full_in    = (bl_sel == BL_FULL);
  assign legal_in   = (bl_sel <= 3'd3) || (full_in && !interleave);
  assign final_beat = busy_q && !full_q && (cnt_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (start) begin
      err_q <= !legal_in;
      busy_q <= legal_in;
      cnt_q <= '0;
      if (legal_in) begin
        base_q <= start_col;
        mask_q <= mask_in;
        full_q <= full_in;
        ilv_q  <= interleave;
        wr_q   <= start_wr;
      end
    end else if (stop) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (final_beat) busy_q <= 1'b0;
      else            cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign col_out   = ilv_q ? (base_q ^ (cnt_q & mask_q))
                           : ((base_q & ~mask_q) | ((base_q + cnt_q) & mask_q));
  assign col_valid = busy_q;
  assign col_last  = final_beat;
  assign col_wr    = wr_q;
  assign mode_err  = err_q;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             start_wr,
  input logic             stop,
  input logic [2:0]       bl_sel,
  input logic             interleave,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last,
  input logic             col_wr,
  input logic             mode_err
);

  logic ok_setting;
  assign ok_setting = (bl_sel <= 3'd3) || (bl_sel == 3'd7 && !interleave);

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && ok_setting |=> col_valid && col_out == $past(start_col) && col_wr == $past(start_wr));

  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !start |=> !col_valid);

  // R9
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !ok_setting |=> mode_err && !col_valid);

  // R5
  run_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last && !start && !stop |=> col_valid);

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !col_valid);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) chk_i (.*);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  logic       clk = 0, rst_n = 0;
  logic       start = 0, start_wr = 0, stop = 0, interleave = 0;
  logic [7:0] start_col = 0;
  logic [2:0] bl_sel = 0;
  logic [7:0] col_out;
  logic       col_valid, col_last, col_wr, mode_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_col_seq dut_i (.*);

  // {bl_sel, interleave, write, start_col}
  localparam logic [12:0] VEC [12] = '{
    {3'd0, 1'b0, 1'b0, 8'h37}, {3'd1, 1'b0, 1'b1, 8'h45},
    {3'd2, 1'b0, 1'b0, 8'h16}, {3'd2, 1'b0, 1'b1, 8'hF3},
    {3'd3, 1'b0, 1'b0, 8'h2D}, {3'd3, 1'b0, 1'b1, 8'hF8},
    {3'd1, 1'b1, 1'b0, 8'h81}, {3'd2, 1'b1, 1'b1, 8'h32},
    {3'd3, 1'b1, 1'b0, 8'h5B}, {3'd3, 1'b1, 1'b1, 8'hC6},
    {3'd0, 1'b1, 1'b0, 8'hAA}, {3'd2, 1'b0, 1'b0, 8'h00}
  };

  function automatic int blen(input logic [2:0] s);
    return (s == 3'd7) ? 256 : (1 << s);
  endfunction

  function automatic logic [7:0] expect_col(input logic [7:0] c, input logic [2:0] s,
                                             input logic ilv, input int i);
    int n = blen(s);
    int lo = c % n;
    if (ilv) return c ^ 8'(i);
    return 8'(c - lo + ((lo + i) % n));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic kick(input logic [2:0] s, input logic ilv, input logic wr, input logic [7:0] c);
    start = 1; bl_sel = s; interleave = ilv; start_wr = wr; start_col = c;
    step;
    start = 0;
  endtask

  task automatic beats(input string req, input logic [2:0] s, input logic ilv,
                       input logic wr, input logic [7:0] c, input int from, input int cnt);
    for (int i = from; i < from + cnt; i++) begin
      chk({req, " valid"}, col_valid, 1);
      chk({req, " col"}, col_out, expect_col(c, s, ilv, i));
      chk({req, " last"}, col_last, (s != 3'd7) && (i == blen(s) - 1));
      chk({req, " wr"}, col_wr, wr);
      if (i < from + cnt - 1) step;
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up;
  end

  initial begin
    #5;
    chk("R1 valid", col_valid, 0);
    chk("R1 last", col_last, 0);
    chk("R1 err", mode_err, 0);
    rst_n = 1;
    step;

    // R2 R3 R4 R6: table of fixed bursts
    for (int v = 0; v < 12; v++) begin
      logic [2:0] s = VEC[v][12:10];
      logic ilv = VEC[v][9];
      logic wr = VEC[v][8];
      logic [7:0] c = VEC[v][7:0];
      kick(s, ilv, wr, c);
      beats(ilv ? "R4" : "R3", s, ilv, wr, c, 0, blen(s));
      step;
      chk("R2 idle after burst", col_valid, 0);
      chk("R6 no last when idle", col_last, 0);
      step;
    end

    // R5: full page across 255 -> 0
    kick(3'd7, 0, 1, 8'hFA);
    beats("R5", 3'd7, 0, 1, 8'hFA, 0, 12);
    step;
    chk("R5 still valid", col_valid, 1);
    chk("R5 col", col_out, 8'h06);
    stop = 1; step; stop = 0;
    chk("R7 stop ends full page", col_valid, 0);
    step;

    // R7: stop mid fixed burst
    kick(3'd3, 0, 0, 8'h10);
    beats("R7", 3'd3, 0, 0, 8'h10, 0, 3);
    stop = 1; step; stop = 0;
    chk("R7 stop mid burst", col_valid, 0);
    step;
    chk("R7 stays idle", col_valid, 0);

    // R7: start with stop, start wins
    kick(3'd2, 0, 0, 8'h20);
    stop = 1; start = 1; bl_sel = 3'd1; start_col = 8'h55; interleave = 0; start_wr = 1;
    step; start = 0; stop = 0;
    beats("R7 start wins", 3'd1, 0, 1, 8'h55, 0, 2);
    step;

    // R8: restart mid burst
    kick(3'd3, 1, 0, 8'h40);
    beats("R8 old", 3'd3, 1, 0, 8'h40, 0, 4);
    kick(3'd2, 0, 1, 8'h9E);
    beats("R8 new", 3'd2, 0, 1, 8'h9E, 0, 4);
    step;
    chk("R8 idle", col_valid, 0);

    // R10: mode inputs change mid burst
    kick(3'd3, 0, 0, 8'h63);
    bl_sel = 3'd0; interleave = 1; start_col = 8'hFF; start_wr = 1;
    beats("R10", 3'd3, 0, 0, 8'h63, 0, 8);
    step;
    chk("R10 ends at 8", col_valid, 0);

    // R11: back-to-back
    kick(3'd1, 0, 0, 8'h0C);
    beats("R11 first", 3'd1, 0, 0, 8'h0C, 0, 2);
    kick(3'd1, 1, 1, 8'h71);
    beats("R11 second", 3'd1, 1, 1, 8'h71, 0, 2);
    step;

    // R9: illegal while idle and busy
    kick(3'd7, 1, 0, 8'h00);
    chk("R9 err", mode_err, 1);
    chk("R9 no beat", col_valid, 0);
    step;
    chk("R9 err held", mode_err, 1);
    kick(3'd3, 0, 0, 8'h08);
    chk("R9 err cleared", mode_err, 0);
    beats("R9 legal", 3'd3, 0, 0, 8'h08, 0, 2);
    kick(3'd5, 0, 0, 8'h00);
    chk("R9 reserved code err", mode_err, 1);
    chk("R9 cancels burst", col_valid, 0);
    step;
    chk("R9 stays cancelled", col_valid, 0);

    finish_up;
  end
endmodule